// File: doc/BRIEF.md
# Transmit Impedance Calibration Request Sequencer

This block runs one transmit impedance calibration on behalf of a calibration engine. When `start_i` arrives while it is idle, it holds the request line low for one cycle and then raises it. This gives the engine a clean rising edge even if the line was left high before. The block then waits a long, fixed settle time. After that it samples the engine's done and error indications, with a fixed gap of cycles between samples. It stops at the first sample that sees either indication, or after a maximum number of samples.

Each run ends with exactly one outcome: completed, error or timeout. The outcome is given as a one-cycle `result_valid_o` pulse, and the code stays on `result_o` until the next run starts. An error or a timeout is only a warning. The sequence still returns to idle normally, so the logic that follows can fall back to default impedance settings.

The engine may signal done or error as a single-cycle pulse at any time after the request rises. For this reason, both indications are captured in sticky flags. These flags are cleared when a new run is accepted. All waits are counted in clock cycles and set by parameters. The defaults correspond to a 20 ms settle time, a 10 us gap and 200 samples at 100 MHz.

Top module: `zcal_req_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `busy_o`, `req_o` and `result_valid_o` are 0.
- R2: A `start_i` seen while `busy_o` is 0 sets `busy_o` in the next cycle. In that cycle `req_o` is 0, and in the cycle after it `req_o` is 1.
- R3: The first status sample is taken after `req_o` has been high for exactly `SETTLE_CYCLES` cycles.
- R4: Status samples are `POLL_GAP_CYCLES + 1` cycles apart. The outcome is reported in the cycle after the deciding sample, so `result_valid_o` rises `3 + SETTLE_CYCLES + (n-1)*(POLL_GAP_CYCLES+1)` cycles after the accepting edge, where n is the number of samples taken.
- R5: Polling stops at the first sample that finds a done or error indication. This includes a one-cycle pulse that occurred at any time since `req_o` rose. Done gives code 2'b00 and error gives code 2'b01.
- R6: If both done and error have been seen by the deciding sample, the code is 2'b00 (completed).
- R7: If none of the `POLL_LIMIT` samples finds done or error, the code is 2'b10 (timeout), reported after the last sample.
- R8: `result_valid_o` is a one-cycle pulse and the code is never 2'b11. `busy_o` is 0 in the following cycle. `result_o` holds its value until the next report.
- R9: A `start_i` seen while `busy_o` is 1 has no effect: the report timing and code of the running sequence are unchanged, and no second run follows it.
- R10: `req_o` is 0 in the cycle in which `result_valid_o` is 1, and it stays 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one calibration run (accepted only when idle) |
| done_i | input | 1 | Calibration finished, from the engine |
| error_i | input | 1 | Calibration failed, from the engine |
| req_o | output | 1 | Calibration request to the engine |
| busy_o | output | 1 | A run is in progress |
| result_valid_o | output | 1 | One-cycle pulse with the outcome |
| result_o | output | 2 | Outcome: 00 completed, 01 error, 10 timeout |

## Verification
The assertions assume that the parameters keep every wait at one cycle or more. They also assume that `start_i` may arrive in any cycle, including while busy or in the reporting cycle. The assertions place no timing constraint on `done_i` or `error_i`. The bench's responder model only pulses done or error while `req_o` is high, at cycle offsets chosen by directed cases or by `$urandom`. Those offsets cover before, on and after each sample point, plus offsets past the last sample. Extra start pulses are injected only in cycles where the block is busy.

// File: rtl/zcal_seq_pkg.sv
package zcal_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LOW,
    ST_SETTLE,
    ST_GAP,
    ST_SAMPLE,
    ST_REPORT
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_DONE    = 2'b00,
    RES_ERROR   = 2'b01,
    RES_TIMEOUT = 2'b10
  } zcal_result_e;

endpackage

// File: rtl/zcal_cycle_timer.sv
module zcal_cycle_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             expired_o
);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/zcal_poll_counter.sv
module zcal_poll_counter #(
  parameter int unsigned LIMIT = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // the sample being taken now is the final one allowed
  assign last_o = (cnt_q == LAST_IDX);

endmodule

// File: rtl/zcal_status_latch.sv
module zcal_status_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic capture_i,
  input  logic done_i,
  input  logic error_i,
  output logic done_seen_o,
  output logic error_seen_o
);

  logic done_q, error_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else if (clear_i) begin
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else if (capture_i) begin
      done_q  <= done_q | done_i;
      error_q <= error_q | error_i;
    end
  end

  // include the current cycle so a pulse coinciding with a sample counts
  assign done_seen_o  = done_q  | (capture_i & done_i);
  assign error_seen_o = error_q | (capture_i & error_i);

endmodule

// File: rtl/zcal_req_seq.sv
module zcal_req_seq #(
  parameter int unsigned SETTLE_CYCLES   = 2_000_000,
  parameter int unsigned POLL_GAP_CYCLES = 1_000,
  parameter int unsigned POLL_LIMIT      = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       error_i,
  output logic       req_o,
  output logic       busy_o,
  output logic       result_valid_o,
  output logic [1:0] result_o
);
  import zcal_seq_pkg::*;

  localparam int unsigned TMAX = (SETTLE_CYCLES > POLL_GAP_CYCLES) ? SETTLE_CYCLES : POLL_GAP_CYCLES;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYCLES - 1);
  localparam logic [TW-1:0] GAP_LD    = TW'(POLL_GAP_CYCLES - 1);

  seq_state_e   state_q, state_d;
  zcal_result_e res_q, res_d;
  logic         res_load;
  logic         tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic         poll_clr, poll_inc, poll_last;
  logic         flag_clr, done_seen, error_seen;
  logic         req_active;

  zcal_cycle_timer #(.WIDTH(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  zcal_poll_counter #(.LIMIT(POLL_LIMIT)) u_polls (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (poll_clr),
    .inc_i   (poll_inc),
    .last_o  (poll_last)
  );

  zcal_status_latch u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (flag_clr),
    .capture_i    (req_active),
    .done_i       (done_i),
    .error_i      (error_i),
    .done_seen_o  (done_seen),
    .error_seen_o (error_seen)
  );

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    res_load = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LD;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    flag_clr = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          flag_clr = 1'b1;
          poll_clr = 1'b1;
          state_d  = ST_REQ_LOW;
        end
      end
      ST_REQ_LOW: begin
        tmr_load = 1'b1;
        tmr_val  = SETTLE_LD;
        state_d  = ST_SETTLE;
      end
      ST_SETTLE, ST_GAP: begin
        if (tmr_expired) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        poll_inc = 1'b1;
        if (done_seen) begin
          res_d    = RES_DONE;
          res_load = 1'b1;
          state_d  = ST_REPORT;
        end else if (error_seen) begin
          res_d    = RES_ERROR;
          res_load = 1'b1;
          state_d  = ST_REPORT;
        end else if (poll_last) begin
          res_d    = RES_TIMEOUT;
          res_load = 1'b1;
          state_d  = ST_REPORT;
        end else begin
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
          state_d  = ST_GAP;
        end
      end
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_DONE;
    end else begin
      state_q <= state_d;
      if (res_load) res_q <= res_d;
    end
  end

  assign req_active     = (state_q == ST_SETTLE) || (state_q == ST_GAP) || (state_q == ST_SAMPLE);
  assign req_o          = req_active;
  assign busy_o         = (state_q != ST_IDLE);
  assign result_valid_o = (state_q == ST_REPORT);
  assign result_o       = res_q;

endmodule

// File: rtl/zcal_req_seq_chk.sv
module zcal_req_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       done_i,
  input logic       error_i,
  input logic       req_o,
  input logic       busy_o,
  input logic       result_valid_o,
  input logic [1:0] result_o
);

  logic unused_inputs;
  assign unused_inputs = done_i ^ error_i;

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !req_o));

  // R2
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(busy_o));

  // R8
  result_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> (!result_valid_o && !busy_o));

  // R8
  result_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (result_o != 2'b11));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |=> (result_valid_o || $stable(result_o)));

  // R10
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o || !busy_o) |-> !req_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !result_valid_o) |=> busy_o);

endmodule

bind zcal_req_seq zcal_req_seq_chk u_chk (.*);

// File: tb/zcal_req_seq_tb.sv
module zcal_req_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int S = 12;
  localparam int G = 3;
  localparam int L = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       done_i = 1'b0;
  logic       error_i = 1'b0;
  logic       req_o, busy_o, result_valid_o;
  logic [1:0] result_o;

  int n_tests = 0;
  int n_fails = 0;
  int t_done = -1;
  int t_err  = -1;
  int rel    = -1;

  zcal_req_seq #(.SETTLE_CYCLES(S), .POLL_GAP_CYCLES(G), .POLL_LIMIT(L)) u_dut (
    .clk_i, .rst_ni, .start_i, .done_i, .error_i,
    .req_o, .busy_o, .result_valid_o, .result_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // engine responder: pulses at cycle offsets counted from the request rise
  always @(negedge clk_i) begin
    rel     = req_o ? rel + 1 : -1;
    done_i  = (rel >= 0) && (rel == t_done);
    error_i = (rel >= 0) && (rel == t_err);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sample_rel(input int k);
    return S + (k - 1) * (G + 1);
  endfunction

  function automatic void predict(input int td, input int te, output int n, output int code);
    int tmin;
    tmin = 1 << 20;
    if (td >= 0) tmin = td;
    if (te >= 0 && te < tmin) tmin = te;
    if (tmin > sample_rel(L)) begin
      n = L;
      code = 2;
    end else begin
      n = (tmin <= S) ? 1 : ((tmin - S) + G) / (G + 1) + 1;
      code = (td >= 0 && td <= sample_rel(n)) ? 0 : 1;
    end
  endfunction

  task automatic run_seq(input int td, input int te, input int ign_at);
    int n, code, lat, exp_lat;
    logic [1:0] held;
    string tag;
    predict(td, te, n, code);
    exp_lat = 3 + S + (n - 1) * (G + 1);
    tag = (code == 2) ? "R7" : ((td >= 0 && te >= 0) ? "R6" : "R5");
    t_done = td;
    t_err  = te;
    @(negedge clk_i);
    start_i = 1'b1;
    lat = 0;
    while (lat < 1000) begin
      @(negedge clk_i);
      lat++;
      start_i = (ign_at > 1 && lat == ign_at && lat < exp_lat) ? 1'b1 : 1'b0;
      if (lat == 1) check(busy_o && !req_o, "R2 req low first", int'(req_o), 0);
      if (lat == 2) check(req_o === 1'b1, "R2 req high second", int'(req_o), 1);
      if (result_valid_o) break;
    end
    start_i = 1'b0;
    check(lat == exp_lat, "R4 report latency", lat, exp_lat);
    check(result_o == 2'(code), tag, int'(result_o), code);
    check(req_o == 1'b0, "R10 req low at report", int'(req_o), 0);
    held = result_o;
    @(negedge clk_i);
    check(!busy_o && !result_valid_o, "R8 single pulse then idle", int'({busy_o, result_valid_o}), 0);
    repeat (4) @(negedge clk_i);
    check(!busy_o && !req_o && result_o == held, "R9 no extra run, R8 code held",
          int'({busy_o, req_o}), 0);
    t_done = -1;
    t_err  = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk_i);
    check(!busy_o && !req_o && !result_valid_o, "R1 in reset", int'({busy_o, req_o, result_valid_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !req_o && !result_valid_o, "R1 after release", int'({busy_o, req_o, result_valid_o}), 0);

    // R3: done during settle seen by first sample
    run_seq(0, -1, 0);
    // R3: error exactly on first sample
    run_seq(-1, S, 0);
    // R4: done just after first sample -> second sample
    run_seq(S + 1, -1, 0);
    // R6: both in the same cycle
    run_seq(5, 5, 0);
    // R5: error early, done much later -> error
    run_seq(20, 3, 0);
    // R6: error then done before the same sample
    run_seq(sample_rel(2), S + 2, 0);
    // R7: nothing happens
    run_seq(-1, -1, 0);
    // R5: done on the last sample
    run_seq(sample_rel(L), -1, 0);
    // R7: done one cycle too late
    run_seq(sample_rel(L) + 1, -1, 0);
    // R9: start pulses while busy
    run_seq(S + 6, -1, 3);
    run_seq(-1, -1, 10);

    for (int i = 0; i < 20; i++) begin
      int td, te, ig;
      td = ($urandom % 4 == 0) ? -1 : int'($urandom % 36);
      te = ($urandom % 3 == 0) ? int'($urandom % 36) : -1;
      ig = ($urandom % 2 == 0) ? 0 : int'($urandom % 14) + 2;
      run_seq(td, te, ig);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

endmodule